// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block gives an 8-bit processor single-beat access to external program memory and external data memory. Each space holds 8 KB. A request carries a 13-bit address, a space select, a direction, write data and a wait-state count. The controller plays that request out on a narrow external bus:
- Five upper address bits sit on their own output.
- The low address byte and the data byte share one multiplexed lane that has an output enable.
- Timing is set by an active-low address strobe and an active-low data strobe.
- A read/write line and a data-space select complete the bus.

Every phase is counted in cycles of a fast internal clock, and each phase length is a parameter of at least one cycle. The order of phases is fixed:
1. Address setup.
2. Address strobe low, which latches the address on its rising edge.
3. Address hold.
4. Turnaround. On a read the lane floats here; on a write it switches to the data byte.
5. Data strobe low. This phase is longer for reads than for writes and is stretched by one cycle per wait state.
6. Data hold.
7. Recovery gap. This gap must pass before another address can go out.

The request side is a valid/ready stream. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the requester must hold its request stable until that edge. A request offered while the controller is busy is neither taken nor queued. The response side is a plain one-cycle `rsp_done` pulse with `rsp_rdata`, and it has no back-pressure.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the lane is released and the bus is at rest:
  - `bus_as_n` and `bus_ds_n` are 1.
  - `bus_ad_oe` is 0.
  - `bus_rw_n` is 1.
  - `bus_dsel` and `bus_ahi` are 0.
  - `req_ready` is 1 and `rsp_done` is 0.
  An asynchronous reset forces this state at once, even in the middle of an access.
- R2: A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is 0 from the cycle after acceptance until the access completes. A `req_valid` raised during that time starts no second address strobe.
- R3: With the default timing:
  - In the first cycle after acceptance, `bus_ad_oe` is 1 and `bus_ad_out` carries `addr[7:0]`, with `bus_as_n` still 1.
  - `bus_as_n` is then low for exactly 2 cycles, the 2nd and 3rd after acceptance.
  - While `bus_as_n` is low, `bus_ad_out` = `addr[7:0]` and stays stable, `bus_ahi` = `addr[12:8]`, and `bus_ad_oe` = 1.
- R4: `bus_ds_n` and `bus_as_n` are never low together. In the turnaround cycle (the 5th after acceptance) both strobes are high, and the lane is either released (read) or carries the write data (write). During a read, `bus_ad_oe` is 0 throughout data-strobe low, which begins in the 6th cycle after acceptance.
- R5: With the default timing, `bus_ds_n` is low for 6 + wait cycles on a read and for 3 + wait cycles on a write.
- R6: On a write, `bus_ad_oe` is 1 and `bus_ad_out` equals the write data from the turnaround cycle through every data-strobe-low cycle, and for one more cycle after `bus_ds_n` rises.
- R7: On a read, the value on `bus_ad_in` in the last data-strobe-low cycle is captured. `rsp_done` pulses high for exactly one cycle, in the first cycle after `bus_ds_n` rises, with that value on `rsp_rdata`. Later changes on `bus_ad_in` do not alter `rsp_rdata`.
- R8: After the data hold cycle there are 2 recovery cycles with both strobes high. `req_ready` returns 3 cycles after `rsp_done`; with L data-strobe cycles, this is the (9+L)th cycle after acceptance.
- R9: `bus_rw_n` is 0 for a write and 1 for a read. `bus_dsel` is 1 for data space and 0 for program space. Both hold their values from address setup through data hold and do not change while `bus_ds_n` is low.
- R10: `req_wait` (0 to 15) adds exactly one data-strobe cycle per count. This holds at the extremes 0 and 15, for both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dspace | input | 1 | 1 = data space, 0 = program space |
| req_addr | input | 13 | Byte address within the selected space |
| req_wdata | input | 8 | Write data |
| req_wait | input | 4 | Wait states added to data-strobe low time |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_done` |
| bus_ahi | output | 5 | Upper address bits |
| bus_ad_out | output | 8 | Multiplexed lane, outgoing value |
| bus_ad_oe | output | 1 | Multiplexed lane output enable |
| bus_ad_in | input | 8 | Multiplexed lane, incoming value |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw_n | output | 1 | Direction, 1 = read |
| bus_dsel | output | 1 | Space select, 1 = data space |

## Verification
Cycle numbering starts at the acceptance edge. With L = base + wait data-strobe cycles:
- The address appears in cycle 1.
- The address strobe is low in cycles 2 and 3.
- The turnaround falls in cycle 5.
- The data strobe is low from cycle 6 through cycle 5+L.
- `rsp_done` and read data are due in cycle 6+L.
- `req_ready` is due in cycle 9+L.

The bench samples every cycle of each access at the falling clock edge. It tallies strobe-low counts and the first cycles of each event, then compares them with these numbers after the access. It checks per-cycle lane content while either strobe is low.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASU  = 3'd1,
    PH_ASL  = 3'd2,
    PH_AH   = 3'd3,
    PH_TURN = 3'd4,
    PH_DS   = 3'd5,
    PH_DH   = 3'd6,
    PH_REC  = 3'd7
  } phase_t;

  function automatic phase_t phase_after(phase_t p);
    case (p)
      PH_ASU:  return PH_ASL;
      PH_ASL:  return PH_AH;
      PH_AH:   return PH_TURN;
      PH_TURN: return PH_DS;
      PH_DS:   return PH_DH;
      PH_DH:   return PH_REC;
      default: return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/xbus_phase_seq.sv
module xbus_phase_seq
  import xbus_pkg::*;
#(
  parameter int P_ASU  = 1,
  parameter int P_ASW  = 2,
  parameter int P_AH   = 1,
  parameter int P_TURN = 1,
  parameter int P_DSR  = 6,
  parameter int P_DSW  = 3,
  parameter int P_DH   = 1,
  parameter int P_REC  = 2,
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cur_wr,
  input  logic [WAIT_W-1:0] cur_wait,
  output phase_t            phase,
  output logic              ds_last
);

  logic [CNT_W-1:0] cnt;
  phase_t           nxt;

  function automatic logic [CNT_W-1:0] len_of(phase_t p, logic wr, logic [WAIT_W-1:0] wt);
    case (p)
      PH_ASU:  return CNT_W'(P_ASU);
      PH_ASL:  return CNT_W'(P_ASW);
      PH_AH:   return CNT_W'(P_AH);
      PH_TURN: return CNT_W'(P_TURN);
      PH_DS:   return (wr ? CNT_W'(P_DSW) : CNT_W'(P_DSR)) + CNT_W'(wt);
      PH_DH:   return CNT_W'(P_DH);
      PH_REC:  return CNT_W'(P_REC);
      default: return CNT_W'(1);
    endcase
  endfunction

  assign nxt     = phase_after(phase);
  assign ds_last = (phase == PH_DS) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_ASU;
        cnt   <= len_of(PH_ASU, cur_wr, cur_wait) - 1'b1;
      end
    end else if (cnt == '0) begin
      phase <= nxt;
      cnt   <= len_of(nxt, cur_wr, cur_wait) - 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2: an access never restarts without passing through idle
  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ASU && $past(phase) != PH_ASU) |-> $past(phase) == PH_IDLE);

endmodule

// File: rtl/xbus_req_hold.sv
module xbus_req_hold #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_wr,
  input  logic              in_dsp,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [WAIT_W-1:0] in_wait,
  input  logic              ds_last,
  input  logic [DATA_W-1:0] lane_in,
  output logic              h_wr,
  output logic              h_dsp,
  output logic [ADDR_W-1:0] h_addr,
  output logic [DATA_W-1:0] h_wdata,
  output logic [WAIT_W-1:0] h_wait,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_wr    <= 1'b0;
      h_dsp   <= 1'b0;
      h_addr  <= '0;
      h_wdata <= '0;
      h_wait  <= '0;
    end else if (start) begin
      h_wr    <= in_wr;
      h_dsp   <= in_dsp;
      h_addr  <= in_addr;
      h_wdata <= in_wdata;
      h_wait  <= in_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= ds_last;
      if (ds_last && !h_wr) rdata <= lane_in;
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 4,
  parameter int P_ASU  = 1,
  parameter int P_ASW  = 2,
  parameter int P_AH   = 1,
  parameter int P_TURN = 1,
  parameter int P_DSR  = 6,
  parameter int P_DSW  = 3,
  parameter int P_DH   = 1,
  parameter int P_REC  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_dspace,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [WAIT_W-1:0]        req_wait,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-DATA_W-1:0] bus_ahi,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_in,
  output logic                     bus_as_n,
  output logic                     bus_ds_n,
  output logic                     bus_rw_n,
  output logic                     bus_dsel
);

  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int MAXLEN = P_ASU + P_ASW + P_AH + P_TURN + P_DSR + P_DSW
                        + P_DH + P_REC + (1 << WAIT_W);
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  phase_t              phase;
  logic                start, ds_last;
  logic                h_wr, h_dsp;
  logic [ADDR_W-1:0]   h_addr;
  logic [DATA_W-1:0]   h_wdata;
  logic [WAIT_W-1:0]   h_wait;
  logic                addr_drive, data_drive, active;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  xbus_req_hold #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_wr(req_write), .in_dsp(req_dspace), .in_addr(req_addr),
    .in_wdata(req_wdata), .in_wait(req_wait),
    .ds_last(ds_last), .lane_in(bus_ad_in),
    .h_wr(h_wr), .h_dsp(h_dsp), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_wait(h_wait), .rdata(rsp_rdata), .done(rsp_done)
  );

  xbus_phase_seq #(
    .P_ASU(P_ASU), .P_ASW(P_ASW), .P_AH(P_AH), .P_TURN(P_TURN),
    .P_DSR(P_DSR), .P_DSW(P_DSW), .P_DH(P_DH), .P_REC(P_REC),
    .WAIT_W(WAIT_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cur_wr(h_wr), .cur_wait(h_wait),
    .phase(phase), .ds_last(ds_last)
  );

  // Pin decode from the registered phase
  assign addr_drive = (phase == PH_ASU) || (phase == PH_ASL) || (phase == PH_AH);
  assign data_drive = h_wr && ((phase == PH_TURN) || (phase == PH_DS) || (phase == PH_DH));
  assign active     = (phase != PH_IDLE) && (phase != PH_REC);

  assign bus_as_n   = (phase != PH_ASL);
  assign bus_ds_n   = (phase != PH_DS);
  assign bus_ad_oe  = addr_drive || data_drive;
  assign bus_ad_out = addr_drive ? h_addr[DATA_W-1:0] :
                      data_drive ? h_wdata : '0;
  assign bus_ahi    = active ? h_addr[ADDR_W-1:DATA_W] : HI_W'(0);
  assign bus_rw_n   = active ? !h_wr : 1'b1;
  assign bus_dsel   = active ? h_dsp : 1'b0;

  // R4: the two strobes are never low together
  p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_as_n && !bus_ds_n));

  // R1: an idle controller does not drive the lane
  p_idle_floats_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_ad_oe && bus_as_n && bus_ds_n));

  // R2: no acceptance while the address strobe is out
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> !req_ready);

  // R3: the address is steady while the address strobe is low
  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> (bus_ad_oe && $stable(bus_ad_out) && $stable(bus_ahi)));

  // R4: a read leaves the lane released under the data strobe
  p_read_floats_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ds_n && bus_rw_n) |-> !bus_ad_oe);

  // R9: direction and space select do not move under the data strobe
  p_ctrl_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> ($stable(bus_rw_n) && $stable(bus_dsel)));

  // R7: completion follows the data-strobe rise
  p_done_after_ds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (bus_ds_n && !$past(bus_ds_n)));

endmodule

// File: tb/tb_xbus_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_dspace = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [3:0]  req_wait = '0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic [4:0]  bus_ahi;
  logic [7:0]  bus_ad_out;
  logic        bus_ad_oe;
  logic [7:0]  bus_ad_in = '0;
  logic        bus_as_n, bus_ds_n, bus_rw_n, bus_dsel;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xbus_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dspace(req_dspace), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wait(req_wait), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_ahi(bus_ahi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
    .bus_rw_n(bus_rw_n), .bus_dsel(bus_dsel)
  );

  // {write, dspace, addr[12:0], wdata, wait, read value}
  localparam logic [34:0] VEC [8] = '{
    {1'b0, 1'b0, 13'h0000, 8'h00, 4'd0,  8'h5A},
    {1'b1, 1'b1, 13'h1FFF, 8'hA5, 4'd0,  8'h00},
    {1'b0, 1'b1, 13'h0A3C, 8'h00, 4'd3,  8'hC3},
    {1'b1, 1'b0, 13'h1234, 8'h3C, 4'd1,  8'h00},
    {1'b0, 1'b0, 13'h1F00, 8'h00, 4'd15, 8'hFF},
    {1'b1, 1'b1, 13'h00FF, 8'h00, 4'd15, 8'h00},
    {1'b0, 1'b1, 13'h1555, 8'h00, 4'd2,  8'h00},
    {1'b1, 1'b0, 13'h0AAA, 8'h81, 4'd7,  8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string req);
    chk(bus_as_n && bus_ds_n && !bus_ad_oe && bus_rw_n && !bus_dsel
        && bus_ahi == 5'd0 && req_ready && !rsp_done, req,
        {bus_as_n, bus_ds_n, bus_ad_oe, bus_rw_n, bus_dsel, req_ready, rsp_done},
        7'b1101010);
  endtask

  task automatic run_vec(input logic wr, input logic dsp, input logic [12:0] addr,
                         input logic [7:0] wd, input logic [3:0] wt, input logic [7:0] rd);
    int len = (wr ? 3 : 6) + int'(wt);
    int as_cnt = 0, ds_cnt = 0, first_as = 0, first_ds = 0;
    int done_cnt = 0, done_n = 0, rdy_n = 0;
    @(negedge clk);
    chk(req_ready, "R2", req_ready, 1);
    req_write = wr; req_dspace = dsp; req_addr = addr;
    req_wdata = wd; req_wait = wt; bus_ad_in = rd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= 12 + len; n++) begin
      if (n == 3) begin req_valid = 1'b1; req_addr = ~addr; end
      if (n == 5) req_valid = 1'b0;
      if (n == 1)
        chk(bus_ad_oe && bus_ad_out == addr[7:0] && bus_as_n, "R3", bus_ad_out, addr[7:0]);
      if (n == 5)
        chk(bus_as_n && bus_ds_n && (wr ? (bus_ad_oe && bus_ad_out == wd) : !bus_ad_oe),
            "R4", bus_ad_oe, wr);
      if (!bus_as_n) begin
        as_cnt++;
        if (first_as == 0) first_as = n;
        chk(bus_ad_oe && bus_ad_out == addr[7:0], "R3", bus_ad_out, addr[7:0]);
        chk(bus_ahi == addr[12:8], "R3", bus_ahi, addr[12:8]);
        chk(bus_rw_n == !wr && bus_dsel == dsp, "R9", {bus_rw_n, bus_dsel}, {!wr, dsp});
      end
      if (!bus_ds_n) begin
        ds_cnt++;
        if (first_ds == 0) first_ds = n;
        if (wr) chk(bus_ad_oe && bus_ad_out == wd, "R6", bus_ad_out, wd);
        else    chk(!bus_ad_oe, "R4", bus_ad_oe, 0);
        chk(bus_rw_n == !wr && bus_dsel == dsp, "R9", {bus_rw_n, bus_dsel}, {!wr, dsp});
      end
      if (rsp_done) begin
        done_cnt++;
        done_n = n;
        if (!wr) chk(rsp_rdata == rd, "R7", rsp_rdata, rd);
      end
      if (n == 6 + len) begin
        if (wr) chk(bus_ad_oe && bus_ad_out == wd && bus_ds_n, "R6", bus_ad_out, wd);
        else    bus_ad_in = ~rd;
      end
      if (req_ready && rdy_n == 0) rdy_n = n;
      @(negedge clk);
    end
    chk(as_cnt == 2, "R2", as_cnt, 2);
    chk(first_as == 2, "R3", first_as, 2);
    chk(first_ds == 6, "R4", first_ds, 6);
    chk(ds_cnt == len, wr ? "R5 write" : "R5 read", ds_cnt, len);
    if (wt == 4'd0 || wt == 4'd15) chk(ds_cnt == len, "R10", ds_cnt, len);
    chk(done_cnt == 1 && done_n == 6 + len, "R7", done_n, 6 + len);
    chk(rdy_n == 9 + len, "R8", rdy_n, 9 + len);
    if (!wr) chk(rsp_rdata == rd, "R7 late lane change", rsp_rdata, rd);
    idle_check("R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1");

    for (int i = 0; i < 8; i++)
      run_vec(VEC[i][34], VEC[i][33], VEC[i][32:20], VEC[i][19:12], VEC[i][11:8], VEC[i][7:0]);

    // Reset in the middle of a read data-strobe phase
    @(negedge clk);
    req_write = 1'b0; req_dspace = 1'b1; req_addr = 13'h0123; req_wait = 4'd4;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(!bus_ds_n, "R5", bus_ds_n, 0);
    rst_n = 1'b0;
    #1;
    idle_check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1");

    // Access still works after the abort
    run_vec(1'b1, 1'b0, 13'h1001, 8'h7E, 4'd0, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule